// File: doc/BRIEF.md
# Bit-Serial Adder with Sequencing Controller

This block adds two unsigned operands one bit position per clock. The operands are placed in two right-shifting registers through a parallel load port while the block is idle. A start pulse then launches a run. On each clock of the run, a one-bit full adder combines the low bits of both registers with a stored carry. The sum bit enters the top of a result register, and both operand registers rotate right by one place.

A three-state controller sequences the work. Its states are idle (00), run (01) and finish (10). A bit-position counter steps once per run clock. When the counter reaches all ones, the controller moves to the finish state for one clock, and there it raises `done`. It then falls back to idle on its own. Because the operand registers rotate rather than drain, they hold their original values again after a run. A second start with no reload therefore repeats the same addition. The width is a parameter and must be a power of two; the default is 8.

Top module: `serial_adder`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `done` is 0, `sum` is 0 and `cout` is 0.
- R2: In idle with `start` low, the block stays idle and `done` stays 0.
- R3: If `start` is sampled high in idle at rising edge k, then `done` is 0 after edges k+1 through k+W-1. It is 1 for exactly the cycle after edge k+W, and 0 again after edge k+W+1.
- R4: While `done` is 1, `sum` equals (A + B) mod 2^W and `cout` equals bit W of A + B. Here A and B are the loaded unsigned operands.
- R5: Every addition begins with a carry-in of 0, whatever carry the previous addition left.
- R6: A high `ld` in idle copies `a_in`/`b_in` into the operand registers. A high `ld` in the run or finish state is ignored and does not change the result.
- R7: A high `start` in the run or finish state is ignored: the result and the `done` timing of the current addition do not change.
- R8: After an addition, the operand registers again hold the loaded operands, so a later start with no reload gives the same result.
- R9: When `ld` and `start` are both high at the same idle edge, the operands loaded at that edge are the ones added.
- R10: In idle with `start` low, `sum` and `cout` hold their values from one clock to the next, whatever `ld` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld | input | 1 | Parallel load of both operands (idle only) |
| a_in | input | W | First operand for parallel load |
| b_in | input | W | Second operand for parallel load |
| start | input | 1 | Launches an addition when sampled in idle |
| done | output | 1 | One-cycle flag, high in the finish state |
| sum | output | W | Result register, least significant bit in bit 0 once complete |
| cout | output | 1 | Carry flip-flop, the carry out of the top bit once complete |

## Verification
The finish flag, the W-bit sum and the carry-out all become due together, W rising edges after the edge that samples `start`. Every rising edge before that point must show `done` low. The flag must be low again one edge later, and the result must then stay put for as long as the block idles. The bench drives inputs on falling edges and samples outputs on the falling edge that follows each rising edge. It counts edges from the start edge, so each value is checked in the exact cycle it is due. Runs that inject a load or a start in mid-addition recheck those same cycles, to show that the intrusion changed nothing.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_DONE = 2'b10
    } sadd_state_e;

    typedef struct packed {
        logic sum;
        logic carry;
    } fa_out_t;

    function automatic fa_out_t full_add(input logic a, input logic b, input logic ci);
        fa_out_t r;
        r.sum   = a ^ b ^ ci;
        r.carry = (a & b) | (a & ci) | (b & ci);
        return r;
    endfunction

    function automatic sadd_state_e next_state(input sadd_state_e cur,
                                               input logic start,
                                               input logic last);
        sadd_state_e n;
        case (cur)
            ST_IDLE: n = start ? ST_RUN : ST_IDLE;
            ST_RUN:  n = last ? ST_DONE : ST_RUN;
            ST_DONE: n = ST_IDLE;
            default: n = ST_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sadd_ctrl.sv
module sadd_ctrl
    import sadd_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output sadd_state_e      st_q,
    output logic [CW-1:0]    cnt_q,
    output logic             run,
    output logic             launch,
    output logic             fin
);
    logic last;

    assign last   = (cnt_q == {CW{1'b1}});
    assign run    = (st_q == ST_RUN);
    assign launch = (st_q == ST_IDLE) && start;
    assign fin    = (st_q == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= next_state(st_q, start, last);
            if (run) cnt_q <= cnt_q + 1'b1;
            else     cnt_q <= '0;
        end
    end
endmodule

// File: rtl/sadd_shreg.sv
module sadd_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_stage
        logic nxt;
        if (i == W-1) begin : g_top
            assign nxt = sin;
        end else begin : g_mid
            assign nxt = q[i+1];
        end
        always_ff @(posedge clk) begin
            if (rst)        q[i] <= 1'b0;
            else if (ld)    q[i] <= d[i];
            else if (shift) q[i] <= nxt;
        end
    end
endmodule

// File: rtl/sadd_bitslice.sv
module sadd_bitslice
    import sadd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic a,
    input  logic b,
    output logic s,
    output logic c_q
);
    fa_out_t r;

    assign r = full_add(a, b, c_q);
    assign s = r.sum;

    always_ff @(posedge clk) begin
        if (rst)      c_q <= 1'b0;
        else if (clr) c_q <= 1'b0;
        else if (en)  c_q <= r.carry;
    end
endmodule

// File: rtl/serial_adder.sv
module serial_adder
    import sadd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         start,
    output logic         done,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    sadd_state_e   st_q;
    logic [CW-1:0] cnt_q;
    logic          run;
    logic          launch;
    logic          ld_ok;
    logic          s_bit;
    logic [W-1:0]  opa_q;
    logic [W-1:0]  opb_q;
    logic [W-1:0]  sum_q;

    sadd_ctrl #(.CW(CW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .st_q(st_q), .cnt_q(cnt_q), .run(run), .launch(launch), .fin(done)
    );

    assign ld_ok = ld && (st_q == ST_IDLE);

    sadd_shreg #(.W(W)) u_opa (
        .clk(clk), .rst(rst), .ld(ld_ok), .d(a_in),
        .shift(run), .sin(opa_q[0]), .q(opa_q)
    );

    sadd_shreg #(.W(W)) u_opb (
        .clk(clk), .rst(rst), .ld(ld_ok), .d(b_in),
        .shift(run), .sin(opb_q[0]), .q(opb_q)
    );

    sadd_shreg #(.W(W)) u_res (
        .clk(clk), .rst(rst), .ld(launch), .d({W{1'b0}}),
        .shift(run), .sin(s_bit), .q(sum_q)
    );

    sadd_bitslice u_fa (
        .clk(clk), .rst(rst), .clr(launch), .en(run),
        .a(opa_q[0]), .b(opb_q[0]), .s(s_bit), .c_q(cout)
    );

    assign sum = sum_q;
endmodule

// File: rtl/serial_adder_chk.sv
module serial_adder_chk
    import sadd_pkg::*;
#(
    parameter int W = 8
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              start,
    input logic                              done,
    input sadd_state_e                       st,
    input logic [((W > 1) ? $clog2(W) : 1)-1:0] cnt,
    input logic [W-1:0]                      sum,
    input logic                              cout
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (!done && sum == '0 && !cout));

    p_stay_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !start) |=> (st == ST_IDLE && !done));

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && cnt != {CW{1'b1}}) |=> (st == ST_RUN && cnt == $past(cnt) + 1'b1));

    p_last_bit_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && cnt == {CW{1'b1}}) |=> done);

    p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && start) |=> (st != ST_IDLE));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !start) |=> ($stable(sum) && $stable(cout)));
endmodule

bind serial_adder serial_adder_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .done(done),
    .st(st_q), .cnt(cnt_q), .sum(sum_q), .cout(cout)
);

// File: tb/serial_adder_bench.sv
`timescale 1ns/1ps
module serial_adder_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ld = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         done;
    logic [W-1:0] sum;
    logic         cout;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    serial_adder #(.W(W)) u_serial_adder (
        .clk(clk), .rst(rst), .ld(ld), .a_in(a_in), .b_in(b_in),
        .start(start), .done(done), .sum(sum), .cout(cout)
    );

    function automatic logic [W:0] ref_add(input logic [W-1:0] a, input logic [W-1:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // load: apply ld first; same_edge: ld together with start (R9);
    // disturb: ld and start pulsed mid-run (R6, R7)
    task automatic do_add(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit load, input bit same_edge, input bit disturb,
                          input logic [W:0] expv, input string tag);
        logic [W-1:0] held;
        @(negedge clk);
        if (load && !same_edge) begin
            ld = 1'b1; a_in = a; b_in = b;
            @(negedge clk);
            ld = 1'b0;
        end
        if (load && same_edge) begin
            ld = 1'b1; a_in = a; b_in = b;
        end
        start = 1'b1;
        @(negedge clk);
        ld = 1'b0; start = 1'b0;
        for (int i = 1; i <= W; i++) begin
            if (disturb && (i == 3 || i == W)) begin
                ld = 1'b1; start = 1'b1; a_in = ~a; b_in = ~b;
            end
            @(negedge clk);
            ld = 1'b0; start = 1'b0;
            if (i < W) chk({"R3 done low mid-run ", tag}, {{W{1'b0}}, done}, '0);
            else begin
                chk({"R3 done at edge k+W ", tag}, {{W{1'b0}}, done}, 1);
                chk({"R4 sum ", tag}, {1'b0, sum}, {1'b0, expv[W-1:0]});
                chk({"R4 cout ", tag}, {{W{1'b0}}, cout}, {{W{1'b0}}, expv[W]});
            end
        end
        held = sum;
        @(negedge clk);
        chk({"R3 done falls ", tag}, {{W{1'b0}}, done}, '0);
        chk({"R10 sum held ", tag}, {cout, sum}, {expv[W], held});
    endtask

    initial begin
        logic [W-1:0] ra, rb;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 done in reset", {{W{1'b0}}, done}, '0);
        chk("R1 result in reset", {cout, sum}, '0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", {done, sum}, '0);

        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R2 idle no start", {{W{1'b0}}, done}, '0);
        end

        do_add(8'h00, 8'h00, 1, 0, 0, ref_add(8'h00, 8'h00), "zero");
        do_add(8'hFF, 8'h01, 1, 0, 0, ref_add(8'hFF, 8'h01), "wrap");
        do_add(8'hFF, 8'hFF, 1, 0, 0, ref_add(8'hFF, 8'hFF), "max");
        do_add(8'h00, 8'h00, 1, 0, 0, 9'h000, "R5 carry cleared");
        do_add(8'h12, 8'h34, 1, 0, 1, ref_add(8'h12, 8'h34), "R6 R7 intrusion");
        do_add(8'h00, 8'h00, 0, 0, 0, ref_add(8'h12, 8'h34), "R8 rerun");
        do_add(8'hA5, 8'h5B, 1, 1, 0, ref_add(8'hA5, 8'h5B), "R9 same edge");

        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            ld = 1'b1; a_in = 8'h77; b_in = 8'h11;
            @(negedge clk);
            ld = 1'b0;
            chk("R10 hold under idle load", {cout, sum}, ref_add(8'hA5, 8'h5B));
            chk("R2 no done in idle", {{W{1'b0}}, done}, '0);
        end
        do_add(8'h00, 8'h00, 0, 0, 0, ref_add(8'h77, 8'h11), "R6 idle load taken");

        for (int n = 0; n < 40; n++) begin
            ra = W'($urandom);
            rb = W'($urandom);
            do_add(ra, rb, 1, ($urandom % 3) == 0, ($urandom % 4) == 0,
                   ref_add(ra, rb), "R4 random");
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R3 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule